// File: doc/BRIEF.md
# Processor Mode and Exception Entry Controller

This block holds the current status word of a processor core. The low five bits of that word hold the operating mode, and the upper bits hold flags. The mode changes for three reasons. An exception event switches to the mode that handles it, and the outgoing status word is saved into a register that belongs to that handler mode. A return strobe copies that mode's saved word back into the current status. A write port lets privileged code replace the status word, while code running in User mode can change only the flags.

Each exception handler mode has its own saved-status register. This lets nested handlers in different modes keep separate return contexts. The core's pipeline drives the event strobes, the write port and the return strobe. It reads back the current mode, a one-bit privilege level and the saved-status register of the current mode.

Top module: `mode_exc_ctrl`

## Requirements
- R1: While reset is asserted, and on its release, the status word is the Supervisor encoding 10011 with all flags zero, and the privilege output is 1. Every saved register holds that same word.
- R2: Mode field encodings are User 10000, FIQ 10001, IRQ 10010, Supervisor 10011, Monitor 10110, Abort 10111, Undefined 11011 and System 11111. An event enters its handler mode on the next clock edge:
  - supervisor call enters Supervisor
  - fast interrupt enters FIQ
  - interrupt enters IRQ
  - prefetch abort and data abort both enter Abort
  - undefined instruction enters Undefined
  - no event ever enters System
- R3: When several events are raised together, one event wins. The order, highest first, is data abort, fast interrupt, interrupt, prefetch abort, undefined instruction, supervisor call. An event also overrides a return or a write made in the same cycle.
- R4: On exception entry, the status word as it was before the edge goes into the saved register of the target mode. The flags are kept and only the mode field changes.
- R5: A return, when no event is present, copies the saved register of the current mode into the whole status word. A return made in User or System mode is ignored.
- R6: The saved-status output shows the saved register of the current mode, and shows zero in User and System modes. An exception entry writes only the register of its own target mode.
- R7: The status word has the mode in bits [4:0] and the flags above them. In any mode other than User, a write loads the flags and any listed mode encoding, System included, on the next edge.
- R8: In User mode, a write loads the flags but leaves the mode as User.
- R9: A write whose mode bits are not a listed encoding loads the flags and keeps the current mode.
- R10: The privilege output is 0 in User mode and 1 in every other mode.
- R11: With the monitor option enabled (the default), a privileged write of 10110 enters Monitor mode, and Monitor has its own saved register. With the option disabled, 10110 is treated as unlisted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_svc_i | input | 1 | Supervisor call strobe |
| evt_fiq_i | input | 1 | Fast interrupt strobe |
| evt_irq_i | input | 1 | Interrupt strobe |
| evt_pabt_i | input | 1 | Prefetch abort strobe |
| evt_dabt_i | input | 1 | Data abort strobe |
| evt_und_i | input | 1 | Undefined instruction strobe |
| wr_en_i | input | 1 | Status word write enable |
| wr_data_i | input | STATUS_W | Status word write value |
| ret_en_i | input | 1 | Return-from-exception strobe |
| status_o | output | STATUS_W | Current status word |
| mode_o | output | 5 | Current mode field |
| priv_o | output | 1 | Privilege level (0 = User) |
| saved_o | output | STATUS_W | Saved status of the current mode |

## Verification
A corrupted mode field is visible on mode_o and priv_o one cycle after the edge that caused it. This holds whether the cause was an arbitration error, a write-filter slip or a wrong restore. A capture into the wrong saved register appears on saved_o in the cycle right after entry, because the output then selects the target mode's register. It appears again one cycle after the next return, which brings back a wrong status word. The bench sweeps all 32 mode encodings from privileged and from User mode, and all 63 event combinations. After each step it compares status, privilege and saved output against a model of the rules.

// File: rtl/mode_ctrl_pkg.sv
package mode_ctrl_pkg;

   localparam int MODE_W     = 5;
   localparam int N_EVT      = 6;
   localparam int N_BANK     = 6;
   localparam int BANK_IDX_W = $clog2(N_BANK);

   typedef enum logic [MODE_W-1:0] {
      MD_USR = 5'b10000,
      MD_FIQ = 5'b10001,
      MD_IRQ = 5'b10010,
      MD_SVC = 5'b10011,
      MD_MON = 5'b10110,
      MD_ABT = 5'b10111,
      MD_UND = 5'b11011,
      MD_SYS = 5'b11111
   } mode_e;

   // Event vector positions, lowest index = highest priority (R3)
   localparam int EV_DABT = 0;
   localparam int EV_FIQ  = 1;
   localparam int EV_IRQ  = 2;
   localparam int EV_PABT = 3;
   localparam int EV_UND  = 4;
   localparam int EV_SVC  = 5;

   // Saved-register bank slots
   localparam int BK_SVC = 0;
   localparam int BK_FIQ = 1;
   localparam int BK_IRQ = 2;
   localparam int BK_ABT = 3;
   localparam int BK_UND = 4;
   localparam int BK_MON = 5;

   function automatic logic [MODE_W-1:0] evt_target(input int idx);
      case (idx)
         EV_DABT: evt_target = MD_ABT;
         EV_FIQ:  evt_target = MD_FIQ;
         EV_IRQ:  evt_target = MD_IRQ;
         EV_PABT: evt_target = MD_ABT;
         EV_UND:  evt_target = MD_UND;
         default: evt_target = MD_SVC;
      endcase
   endfunction

   function automatic logic mode_listed(input logic [MODE_W-1:0] m, input logic mon_ok);
      case (m)
         MD_USR, MD_FIQ, MD_IRQ, MD_SVC, MD_ABT, MD_UND, MD_SYS: mode_listed = 1'b1;
         MD_MON:  mode_listed = mon_ok;
         default: mode_listed = 1'b0;
      endcase
   endfunction

   function automatic logic mode_banked(input logic [MODE_W-1:0] m);
      case (m)
         MD_SVC, MD_FIQ, MD_IRQ, MD_ABT, MD_UND, MD_MON: mode_banked = 1'b1;
         default: mode_banked = 1'b0;
      endcase
   endfunction

   function automatic logic [BANK_IDX_W-1:0] mode_bank(input logic [MODE_W-1:0] m);
      case (m)
         MD_FIQ:  mode_bank = BANK_IDX_W'(BK_FIQ);
         MD_IRQ:  mode_bank = BANK_IDX_W'(BK_IRQ);
         MD_ABT:  mode_bank = BANK_IDX_W'(BK_ABT);
         MD_UND:  mode_bank = BANK_IDX_W'(BK_UND);
         MD_MON:  mode_bank = BANK_IDX_W'(BK_MON);
         default: mode_bank = BANK_IDX_W'(BK_SVC);
      endcase
   endfunction

endpackage

// File: rtl/mode_evt_arb.sv
module mode_evt_arb
   import mode_ctrl_pkg::*;
(
   input  logic [N_EVT-1:0]  evt_i,
   output logic              take_o,
   output logic [N_EVT-1:0]  grant_o,
   output logic [MODE_W-1:0] tgt_o
);

   logic [MODE_W-1:0] part [N_EVT];

   // Fixed priority: first set bit from index 0 wins
   always_comb begin
      logic found;
      found   = 1'b0;
      grant_o = '0;
      for (int i = 0; i < N_EVT; i++) begin
         if (evt_i[i] && !found) begin
            grant_o[i] = 1'b1;
            found      = 1'b1;
         end
      end
   end

   genvar g;
   generate
      for (g = 0; g < N_EVT; g++) begin : g_tgt
         assign part[g] = grant_o[g] ? evt_target(g) : '0;
      end
   endgenerate

   always_comb begin
      tgt_o = '0;
      for (int i = 0; i < N_EVT; i++) tgt_o = tgt_o | part[i];
   end

   assign take_o = |evt_i;

endmodule

// File: rtl/mode_saved_bank.sv
module mode_saved_bank
   import mode_ctrl_pkg::*;
#(
   parameter int                STATUS_W = 32,
   parameter logic [STATUS_W-1:0] RST_VAL = '0
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cap_en_i,
   input  logic [BANK_IDX_W-1:0] cap_idx_i,
   input  logic [STATUS_W-1:0]   cap_data_i,
   input  logic                  rd_en_i,
   input  logic [BANK_IDX_W-1:0] rd_idx_i,
   output logic [STATUS_W-1:0]   rd_data_o
);

   logic [STATUS_W-1:0] bank_q [N_BANK];
   logic [N_BANK-1:0]   we;

   genvar b;
   generate
      for (b = 0; b < N_BANK; b++) begin : g_bank
         assign we[b] = cap_en_i && (cap_idx_i == BANK_IDX_W'(b));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     bank_q[b] <= RST_VAL;
            else if (we[b]) bank_q[b] <= cap_data_i;
         end
      end
   endgenerate

   always_comb begin
      rd_data_o = '0;
      if (rd_en_i && (int'(rd_idx_i) < N_BANK)) rd_data_o = bank_q[rd_idx_i];
   end

   // R6: an entry touches at most one saved register
   a_r6_one_bank_written: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(we) <= 1);

   // R6: a capture request always lands in some bank
   a_r6_capture_lands: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en_i |-> (we != '0));

endmodule

// File: rtl/mode_status_reg.sv
module mode_status_reg
   import mode_ctrl_pkg::*;
#(
   parameter int                  STATUS_W = 32,
   parameter bit                  MON_EN   = 1'b1,
   parameter logic [STATUS_W-1:0] RST_VAL  = '0
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                take_i,
   input  logic [MODE_W-1:0]   tgt_i,
   input  logic                ret_i,
   input  logic [STATUS_W-1:0] ret_data_i,
   input  logic                wr_i,
   input  logic [STATUS_W-1:0] wr_data_i,
   output logic [STATUS_W-1:0] status_o
);

   localparam int FLAG_W = STATUS_W - MODE_W;

   logic                mon_ok;
   logic [STATUS_W-1:0] status_q, status_d;
   logic [MODE_W-1:0]   cur_mode, req_mode;
   logic                keep_mode;

   generate
      if (STATUS_W <= MODE_W) begin : g_bad_width
         $error("status word must be wider than the mode field");
      end
      if (MON_EN) begin : g_mon
         assign mon_ok = 1'b1;
      end else begin : g_no_mon
         assign mon_ok = 1'b0;
      end
   endgenerate

   assign cur_mode  = status_q[MODE_W-1:0];
   assign req_mode  = wr_data_i[MODE_W-1:0];
   assign keep_mode = (cur_mode == MD_USR) || !mode_listed(req_mode, mon_ok);

   always_comb begin
      status_d = status_q;
      if (take_i)
         status_d = {status_q[STATUS_W-1:MODE_W], tgt_i};
      else if (ret_i)
         status_d = ret_data_i;
      else if (wr_i)
         status_d = {wr_data_i[STATUS_W-1:MODE_W], keep_mode ? cur_mode : req_mode};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q <= RST_VAL;
      else        status_q <= status_d;
   end

   assign status_o = status_q;

   // R9: the mode field never holds an unlisted encoding
   a_r9_mode_listed: assert property (@(posedge clk) disable iff (!rst_n)
      mode_listed(status_q[MODE_W-1:0], mon_ok));

   // R8: a plain write in User mode leaves User mode in place
   a_r8_user_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_mode == MD_USR && wr_i && !take_i && !ret_i) |=> (status_q[MODE_W-1:0] == MD_USR));

   // R7: a plain write always loads the flags
   a_r7_flags_loaded: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !take_i && !ret_i) |=>
         (status_q[STATUS_W-1:MODE_W] == $past(wr_data_i[STATUS_W-1:MODE_W])));

   // R2: no exception lands in System mode
   a_r2_no_sys_entry: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |=> (status_q[MODE_W-1:0] != MD_SYS));

   // R4: entry keeps the flags
   a_r4_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |=> $stable(status_q[STATUS_W-1:MODE_W]));

   initial begin
      if (FLAG_W < 1) $error("no flag bits");
   end

endmodule

// File: rtl/mode_exc_ctrl.sv
module mode_exc_ctrl
   import mode_ctrl_pkg::*;
#(
   parameter int STATUS_W = 32,
   parameter bit MON_EN   = 1'b1
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                evt_svc_i,
   input  logic                evt_fiq_i,
   input  logic                evt_irq_i,
   input  logic                evt_pabt_i,
   input  logic                evt_dabt_i,
   input  logic                evt_und_i,
   input  logic                wr_en_i,
   input  logic [STATUS_W-1:0] wr_data_i,
   input  logic                ret_en_i,
   output logic [STATUS_W-1:0] status_o,
   output logic [MODE_W-1:0]   mode_o,
   output logic                priv_o,
   output logic [STATUS_W-1:0] saved_o
);

   localparam logic [STATUS_W-1:0] RST_STATUS =
      {{(STATUS_W-MODE_W){1'b0}}, MODE_W'(MD_SVC)};

   logic [N_EVT-1:0]  evt;
   logic [N_EVT-1:0]  grant;
   logic              take;
   logic [MODE_W-1:0] tgt;
   logic              ret_ok;
   logic              cur_banked;

   always_comb begin
      evt          = '0;
      evt[EV_DABT] = evt_dabt_i;
      evt[EV_FIQ]  = evt_fiq_i;
      evt[EV_IRQ]  = evt_irq_i;
      evt[EV_PABT] = evt_pabt_i;
      evt[EV_UND]  = evt_und_i;
      evt[EV_SVC]  = evt_svc_i;
   end

   mode_evt_arb u_arb (
      .evt_i   (evt),
      .take_o  (take),
      .grant_o (grant),
      .tgt_o   (tgt)
   );

   assign cur_banked = mode_banked(mode_o);
   assign ret_ok     = ret_en_i && !take && cur_banked;

   mode_saved_bank #(
      .STATUS_W (STATUS_W),
      .RST_VAL  (RST_STATUS)
   ) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .cap_en_i   (take),
      .cap_idx_i  (mode_bank(tgt)),
      .cap_data_i (status_o),
      .rd_en_i    (cur_banked),
      .rd_idx_i   (mode_bank(mode_o)),
      .rd_data_o  (saved_o)
   );

   mode_status_reg #(
      .STATUS_W (STATUS_W),
      .MON_EN   (MON_EN),
      .RST_VAL  (RST_STATUS)
   ) u_stat (
      .clk        (clk),
      .rst_n      (rst_n),
      .take_i     (take),
      .tgt_i      (tgt),
      .ret_i      (ret_ok),
      .ret_data_i (saved_o),
      .wr_i       (wr_en_i),
      .wr_data_i  (wr_data_i),
      .status_o   (status_o)
   );

   assign mode_o = status_o[MODE_W-1:0];
   assign priv_o = (mode_o != MD_USR);

   // R2: entry lands in the arbitrated target mode
   a_r2_entry_mode: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (mode_o == $past(tgt)));

   // R3: one winner, and the data abort always wins
   a_r3_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && (take == (grant != '0)));
   a_r3_dabt_first: assert property (@(posedge clk) disable iff (!rst_n)
      evt_dabt_i |=> (mode_o == MD_ABT));

   // R4: the new mode's saved register shows the pre-entry status
   a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (saved_o == $past(status_o)));

   // R5: a return restores the saved word
   a_r5_restore: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_en_i && !take && cur_banked) |=> (status_o == $past(saved_o)));

   // R6: no saved word is shown outside the handler modes
   a_r6_unbanked_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !cur_banked |-> (saved_o == '0));

   // R10: every exception ends privileged
   a_r10_priv_after_entry: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> priv_o);

endmodule

// File: tb/mode_exc_ctrl_tb.sv
module mode_exc_ctrl_tb;

   localparam int W = 8;
   localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                          SVC = 5'b10011, MON = 5'b10110, ABT = 5'b10111,
                          UND = 5'b11011, SYS = 5'b11111;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic         rst_n = 1'b0;
   logic         e_svc = 0, e_fiq = 0, e_irq = 0, e_pabt = 0, e_dabt = 0, e_und = 0;
   logic         wr = 0, ret = 0;
   logic [W-1:0] wd = '0;
   logic [W-1:0] status, saved;
   logic [4:0]   mode;
   logic         priv;

   mode_exc_ctrl #(.STATUS_W(W)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .evt_svc_i(e_svc), .evt_fiq_i(e_fiq), .evt_irq_i(e_irq),
      .evt_pabt_i(e_pabt), .evt_dabt_i(e_dabt), .evt_und_i(e_und),
      .wr_en_i(wr), .wr_data_i(wd), .ret_en_i(ret),
      .status_o(status), .mode_o(mode), .priv_o(priv), .saved_o(saved)
   );

   int errors = 0, checks = 0;
   bit done = 0;

   // model state
   logic [W-1:0] m_st;
   logic [W-1:0] m_sv [6];

   function automatic int slot(input logic [4:0] m);
      case (m)
         SVC: return 0; FIQ: return 1; IRQ: return 2;
         ABT: return 3; UND: return 4; MON: return 5;
         default: return -1;
      endcase
   endfunction

   function automatic bit listed(input logic [4:0] m);
      return (m == USR || m == FIQ || m == IRQ || m == SVC ||
              m == MON || m == ABT || m == UND || m == SYS);
   endfunction

   // event bits: [0]svc [1]fiq [2]irq [3]pabt [4]dabt [5]und ; R3 order
   function automatic logic [4:0] winner(input logic [5:0] e);
      if (e[4]) return ABT;
      if (e[1]) return FIQ;
      if (e[2]) return IRQ;
      if (e[3]) return ABT;
      if (e[5]) return UND;
      if (e[0]) return SVC;
      return 5'b0;
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      logic [W-1:0] exp_sv;
      int s;
      s = slot(m_st[4:0]);
      exp_sv = (s >= 0) ? m_sv[s] : '0;
      chk(status === m_st, tag, "status", status, m_st);
      chk(saved === exp_sv, tag, "saved", saved, exp_sv);
      chk(priv === (m_st[4:0] != USR), {tag, "/R10"}, "priv",
          W'(priv), W'(m_st[4:0] != USR));
   endtask

   task automatic step(input logic [5:0] e, input bit w, input logic [W-1:0] d,
                       input bit r, input string tag);
      logic [4:0] t;
      int s;
      {e_und, e_dabt, e_pabt, e_irq, e_fiq, e_svc} = e;
      wr = w; wd = d; ret = r;
      @(posedge clk);
      #1;
      {e_und, e_dabt, e_pabt, e_irq, e_fiq, e_svc} = '0;
      wr = 0; ret = 0;
      // model update from the requirement rules
      t = winner(e);
      s = slot(m_st[4:0]);
      if (e != 0) begin
         m_sv[slot(t)] = m_st;
         m_st = {m_st[W-1:5], t};
      end else if (r && s >= 0) begin
         m_st = m_sv[s];
      end else if (w) begin
         if (m_st[4:0] != USR && listed(d[4:0])) m_st = d;
         else m_st = {d[W-1:5], m_st[4:0]};
      end
      compare(tag);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      m_st = {3'b0, SVC};
      for (int i = 0; i < 6; i++) m_sv[i] = {3'b0, SVC};
      #12;
      compare("R1");                 // during reset
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      compare("R1");                 // after release

      // R7 / R9 / R11: all encodings from a privileged mode
      for (int enc = 0; enc < 32; enc++) begin
         step(6'b0, 1'b1, {3'(enc), 5'(enc)}, 1'b0, listed(5'(enc)) ? "R7" : "R9");
         step(6'b000001, 1'b0, '0, 1'b0, "R2");   // svc call back to Supervisor
      end

      // R8: all encodings from User mode; return in User ignored (R5)
      step(6'b0, 1'b1, {3'b101, USR}, 1'b0, "R7");
      for (int enc = 0; enc < 32; enc++)
         step(6'b0, 1'b1, {3'(enc + 3), 5'(enc)}, 1'b0, "R8");
      step(6'b0, 1'b0, '0, 1'b1, "R5");
      step(6'b000001, 1'b0, '0, 1'b0, "R2");

      // R2/R3/R4/R5: every event combination from System mode
      for (int c = 1; c < 64; c++) begin
         step(6'b0, 1'b1, {3'(c), SYS}, 1'b0, "R7");
         // odd combos also carry a write and a return that must lose (R3)
         step(6'(c), c[0], {3'b111, USR}, c[0], "R3");
         step(6'b0, 1'b0, '0, 1'b1, "R5");          // back to System
         step(6'b0, 1'b0, '0, 1'b1, "R5");          // ignored in System
      end

      // R6: separate saved registers per handler mode
      step(6'b0, 1'b1, {3'b001, SYS}, 1'b0, "R7");
      step(6'b000010, 1'b0, '0, 1'b0, "R6");       // FIQ captures 001
      step(6'b0, 1'b1, {3'b010, SYS}, 1'b0, "R7");
      step(6'b000100, 1'b0, '0, 1'b0, "R6");       // IRQ captures 010
      step(6'b0, 1'b1, {3'b110, FIQ}, 1'b0, "R6"); // FIQ saved still 001
      step(6'b0, 1'b0, '0, 1'b1, "R6");

      // R11: Monitor by write, own saved register, return from it
      step(6'b0, 1'b1, {3'b011, MON}, 1'b0, "R11");
      step(6'b100000, 1'b0, '0, 1'b0, "R11");      // undefined from Monitor
      step(6'b0, 1'b0, '0, 1'b1, "R11");           // back to Monitor
      step(6'b0, 1'b0, '0, 1'b1, "R11");           // Monitor's own restore

      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule